// File: doc/BRIEF.md
# Dual-Mode Reference Clock Divider

This block divides an incoming reference clock (crystal or external source, up to 8 MHz) down to the comparison rate that a phase/frequency detector needs. It holds two sets of division ratios, one for each control-bus mode. A single mode input chooses which set is active.

In the two-wire mode, a 3-bit code chooses among seven ratios or an off setting. In the three-wire mode, the two low code bits and a separate select pin together choose the ratio.

The block drives two outputs. The first is a comparison pulse that is one reference cycle wide and marks each terminal count. The second is a divided square-wave indication at the same rate. A new ratio is never applied in the middle of a period: it is taken up at the next terminal count, so no short period ever reaches the detector.

Top module: `refdiv_dual`

## Requirements
- R1: With `bus_mode`=0 (two-wire), `ratio_code` selects the period in reference cycles as 0→25, 1→50, 2→140, 3→250, 4→256, 5→512, 7→1024, and code 6 means off. `ref_sel` has no effect in this mode.
- R2: With `bus_mode`=1 (three-wire) and `ref_sel`=0, `ratio_code[1:0]` values 0, 1, 2, 3 give periods of 25, 50, 140 and 250.
- R3: With `bus_mode`=1 and `ref_sel`=1, `ratio_code[1:0]` values 0, 1, 2, 3 give periods of 50, 100, 280 and 500.
- R4: In three-wire mode, `ratio_code[2]` has no effect. For example, code 7 with `ref_sel`=0 gives a period of 250, not off and not 1024.
- R5: `cmp_pulse` is high for exactly one clock cycle per period. Consecutive pulses are exactly N cycles apart, where N is the active ratio.
- R6: Within each period, `cmp_half` is high for N − floor(N/2) cycles. It is low in every cycle where `cmp_pulse` is high.
- R7: While the off setting is active, both `cmp_pulse` and `cmp_half` stay low. If a non-off selection is sampled at rising edge e during off, the first pulse is seen after edge e+N. If off is selected during a running period, that period still completes with its pulse, and then the outputs go quiet.
- R8: A change of selection in the middle of a period does not alter that period. The new ratio applies from the period that starts at the next terminal count.
- R9: `rst` is synchronous and active high. While it is asserted, both outputs are low. The first pulse is seen after the N-th rising edge that has `rst` low, where N is the ratio selected while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | 0 = two-wire ratio set, 1 = three-wire ratio set |
| ratio_code | input | 3 | Ratio selection code |
| ref_sel | input | 1 | Select pin that picks the upper ratio group in three-wire mode |
| cmp_pulse | output | 1 | One-cycle comparison pulse at each terminal count |
| cmp_half | output | 1 | Divided square-wave indication |

## Verification
The hardest behaviour to reach from the ports is the timing of a ratio change relative to the terminal count. This covers three cases: a change made mid-period, a change into the off setting while the divider is running, and the restart out of the off setting. To reach these, the stimulus keeps a count of rising edges. It changes the code at a chosen edge offset inside a period, and it derives the expected pulse edges from that offset. A scoreboard compares each pulse's edge number, and the number of high cycles of the square indication before it, against the queued expectations. Any pulse that arrives with nothing expected is reported.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int unsigned MAX_RATIO = 1024;
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef enum logic {
    BUS_TWO_WIRE   = 1'b0,
    BUS_THREE_WIRE = 1'b1
  } bus_mode_e;

  // Returns the division ratio, or 0 for the off setting.
  function automatic int unsigned pick_ratio(input logic three_wire,
                                             input logic [2:0] code,
                                             input logic sel);
    int unsigned r;
    r = 0;
    if (!three_wire) begin
      case (code)
        3'd0:    r = 25;
        3'd1:    r = 50;
        3'd2:    r = 140;
        3'd3:    r = 250;
        3'd4:    r = 256;
        3'd5:    r = 512;
        3'd6:    r = 0;
        default: r = 1024;
      endcase
    end else if (!sel) begin
      case (code[1:0])
        2'd0:    r = 25;
        2'd1:    r = 50;
        2'd2:    r = 140;
        default: r = 250;
      endcase
    end else begin
      case (code[1:0])
        2'd0:    r = 50;
        2'd1:    r = 100;
        2'd2:    r = 280;
        default: r = 500;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
  import refdiv_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic             bus_mode,
  input  logic [2:0]       ratio_code,
  input  logic             ref_sel,
  output logic [CNT_W-1:0] dec_ratio,
  output logic             dec_off
);

  int unsigned raw;

  always_comb begin
    raw       = pick_ratio(bus_mode == BUS_THREE_WIRE, ratio_code, ref_sel);
    dec_ratio = CNT_W'(raw);
    dec_off   = (raw == 0);
  end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] dec_ratio,
  input  logic             dec_off,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] half_nxt,
  output logic             off_nxt,
  output logic             act_off
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_ratio;
  logic [CNT_W-1:0] ratio_nxt;

  always_comb begin
    wrap      = !act_off && (cnt == act_ratio - 1'b1);
    cnt_nxt   = cnt + 1'b1;
    ratio_nxt = act_ratio;
    off_nxt   = act_off;
    if (act_off || wrap) begin
      cnt_nxt   = '0;
      ratio_nxt = dec_ratio;
      off_nxt   = dec_off;
    end
    half_nxt = ratio_nxt >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_ratio <= dec_ratio;
      act_off   <= dec_off;
    end else begin
      cnt       <= cnt_nxt;
      act_ratio <= ratio_nxt;
      act_off   <= off_nxt;
    end
  end

  // R5: the count never leaves the active period
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    !act_off |-> (cnt < act_ratio));

  // R8: the active ratio is only replaced at a terminal count or from off
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !act_off) |=> $stable(act_ratio));

endmodule

// File: rtl/refdiv_outreg.sv
module refdiv_outreg #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] half_nxt,
  input  logic             off_nxt,
  output logic             pulse_q,
  output logic             half_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      pulse_q <= wrap;
      half_q  <= !off_nxt && (cnt_nxt >= half_nxt);
    end
  end

  // R5: pulse lasts one cycle
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R9: outputs quiet after a reset cycle
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!pulse_q && !half_q));

endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual
  import refdiv_pkg::*;
#(
  parameter int unsigned CNT_W = RATIO_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_mode,
  input  logic [2:0] ratio_code,
  input  logic       ref_sel,
  output logic       cmp_pulse,
  output logic       cmp_half
);

  logic [CNT_W-1:0] dec_ratio;
  logic             dec_off;
  logic             wrap;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] half_nxt;
  logic             off_nxt;
  logic             act_off;

  refdiv_ratio_sel #(.CNT_W(CNT_W)) u_sel (
    .bus_mode   (bus_mode),
    .ratio_code (ratio_code),
    .ref_sel    (ref_sel),
    .dec_ratio  (dec_ratio),
    .dec_off    (dec_off)
  );

  refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .dec_ratio (dec_ratio),
    .dec_off   (dec_off),
    .wrap      (wrap),
    .cnt_nxt   (cnt_nxt),
    .half_nxt  (half_nxt),
    .off_nxt   (off_nxt),
    .act_off   (act_off)
  );

  refdiv_outreg #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .cnt_nxt  (cnt_nxt),
    .half_nxt (half_nxt),
    .off_nxt  (off_nxt),
    .pulse_q  (cmp_pulse),
    .half_q   (cmp_half)
  );

  // R6: square indication is low while the pulse is high
  p_sq_low_r6: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> !cmp_half);

  // R7: off setting keeps both outputs low
  p_off_silent_r7: assert property (@(posedge clk) disable iff (rst)
    act_off |=> (!cmp_pulse && !cmp_half));

endmodule

// File: tb/refdiv_dual_tb.sv
`timescale 1ns/1ps
module refdiv_dual_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_mode = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic       ref_sel = 1'b0;
  logic       cmp_pulse;
  logic       cmp_half;

  always #10 clk = ~clk;

  refdiv_dual u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_mode   (bus_mode),
    .ratio_code (ratio_code),
    .ref_sel    (ref_sel),
    .cmp_pulse  (cmp_pulse),
    .cmp_half   (cmp_half)
  );

  typedef struct {
    int    at;
    int    highs;
    string req;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  int   edge_n = 0;
  int   nxt = 0;
  int   sq_cnt = 0;
  bit   prev_p = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  // Monitor: pops expected pulses and compares.
  always @(negedge clk) begin
    if (rst) begin
      sq_cnt = 0;
      prev_p = 1'b0;
    end else begin
      if (cmp_pulse) begin
        tests++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R5/R7: unexpected pulse at edge %0d, expected none", edge_n);
        end else begin
          exp_t it;
          it = q.pop_front();
          if (edge_n != it.at || sq_cnt != it.highs || prev_p || cmp_half) begin
            fails++;
            $display("FAIL %s: pulse edge %0d highs %0d prev %0b half %0b, expected edge %0d highs %0d prev 0 half 0",
                     it.req, edge_n, sq_cnt, prev_p, cmp_half, it.at, it.highs);
          end
        end
        sq_cnt = 0;
      end else if (cmp_half) begin
        sq_cnt++;
      end
      prev_p = cmp_pulse;
    end
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic start(input logic m, input logic [2:0] c, input logic s);
    @(negedge clk);
    bus_mode = m; ratio_code = c; ref_sel = s; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!cmp_pulse && !cmp_half, "R9", "outputs in reset",
        {cmp_pulse, cmp_half}, 0);
    rst = 1'b0;
    nxt = edge_n;
  endtask

  task automatic expect_n(input int n, input int periods, input string r);
    for (int i = 0; i < periods; i++) begin
      nxt += n;
      q.push_back('{at: nxt, highs: n - n / 2, req: r});
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL %s: %0d pulses missing, expected 0 missing", q[0].req, q.size());
      q.delete();
    end
  endtask

  task automatic quiet(input int cycles, input string r);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cmp_pulse || cmp_half) seen++;
    end
    chk(seen == 0, r, "active cycles while off", seen, 0);
  endtask

  int tw[8] = '{25, 50, 140, 250, 256, 512, 0, 1024};
  int tl[4] = '{25, 50, 140, 250};
  int th[4] = '{50, 100, 280, 500};

  initial begin
    // R1: two-wire table, ref_sel toggled to show it is ignored
    for (int c = 0; c < 8; c++) begin
      if (c != 6) begin
        start(1'b0, 3'(c), c[0]);
        expect_n(tw[c], 3, "R1");
        drain();
      end
    end
    // R2 / R3: three-wire tables
    for (int c = 0; c < 4; c++) begin
      start(1'b1, 3'(c), 1'b0);
      expect_n(tl[c], 3, "R2");
      drain();
      start(1'b1, 3'(c), 1'b1);
      expect_n(th[c], 3, "R3");
      drain();
    end
    // R4: upper code bit ignored in three-wire mode
    start(1'b1, 3'b111, 1'b0);
    expect_n(250, 2, "R4");
    drain();
    start(1'b1, 3'b100, 1'b1);
    expect_n(50, 2, "R4");
    drain();
    // R8: mid-period change from 50 to 25
    start(1'b0, 3'd1, 1'b0);
    begin
      int base;
      base = nxt;
      expect_n(50, 1, "R8");
      while (edge_n < base + 10) @(negedge clk);
      ratio_code = 3'd0;
      expect_n(25, 3, "R8");
      drain();
    end
    // R7: off from reset, then leave off
    start(1'b0, 3'd6, 1'b0);
    quiet(300, "R7");
    @(negedge clk);
    ratio_code = 3'd0;
    nxt = edge_n + 1;
    expect_n(25, 3, "R7");
    drain();
    // R7: going off mid-period completes the current period
    start(1'b0, 3'd0, 1'b0);
    begin
      int base;
      base = nxt;
      expect_n(25, 1, "R7");
      while (edge_n < base + 10) @(negedge clk);
      ratio_code = 3'd6;
      drain();
      quiet(200, "R7");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule